// File: doc/BRIEF.md
# Eight-Channel Edge/Center-Aligned PWM Timer

This block drives eight pulse-width-modulated outputs from a single shared 16-bit counter. Every channel holds its own compare value and control bits. The counter starts at a programmable start value and runs up to a programmable top value. A mode bit chooses the sweep shape. In edge-aligned mode the counter climbs from start to top and then reloads the start value. In center-aligned mode it climbs from start to top and then falls back to start. A 3-bit field divides the selected count source by a power of two. A 2-bit field picks the count source: stopped, every system clock, a fixed-rate tick input or an external tick input.

Software configures the block through a simple synchronous register port. The port takes a write strobe, an address and write data, and it returns read data combinationally for the address presented. The top value and the compare values are double-buffered. A write to either lands in a shadow register. The shadow is copied into the working register only at the end of a period, or at any time while the counter is stopped, so a period already in progress is never cut short. A mask register forces selected pins to their inactive level. An init register supplies the pin level whenever the counter is stopped or a channel is not in PWM mode.

Top module: `pwm_timer`

## Requirements
- R1: After a synchronous reset all registers read 0, the counter is stopped at 0 and every output pin is 0.
- R2: Control bits 4:3 choose the count source: 0 stops the counter and its value holds; 1 advances on every clock; 2 advances on each cycle with `fix_tick` high; 3 advances on each cycle with `ext_tick` high.
- R3: Control bits 2:0 hold a value p, and the counter advances once per 2^p selected source events, so with the system clock the output period and high time scale by 2^p.
- R4: With control bit 5 clear (edge-aligned), one period lasts top−start+1 counts and a high-true output is active for compare−start counts, starting at the reload.
- R5: With control bit 5 set (center-aligned), the counter sweeps up from start to top and down to start; one period lasts 2·(top−start) counts and a high-true output is active for 2·(compare−start) counts.
- R6: In a channel control word, bit 5 enables PWM, bit 3 selects active-high and bit 2 selects active-low, with bit 3 taking precedence; an active-low pin is the inverse of the active state.
- R7: A compare value at or below the start value keeps the channel inactive for the whole period; a compare value above the top value keeps it active for the whole period.
- R8: Writes to the top value (offset 0x08) and to a compare value are held in a shadow register and take effect only at the end of the current period, or at once while the counter is stopped.
- R9: A set bit n in the mask register (offset 0x60) drives pin n to its inactive level: 1 for an active-low channel, otherwise 0.
- R10: For an unmasked channel, the pin equals bit n of the init register (offset 0x5C) while the counter is stopped or the channel has PWM disabled.
- R11: Any write to the counter register (offset 0x04) restarts the count at the start value in the up direction and clears the prescaler.
- R12: Register map: control at 0x00, counter at 0x04, top at 0x08, start value at 0x4C, and channel n control at 0x0C+8n and compare at 0x10+8n; reads return the last value written (for the counter, the live count).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fix_tick | input | 1 | Fixed-rate count enable, one pulse per event |
| ext_tick | input | 1 | External count enable, one pulse per event |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 8 | Channel output pins |

## Verification
A corrupted counter or direction bit shows up within one period as a wrong high-time count or a wrong rising-edge spacing on the pins. It also shows up in the live count that is read back at offset 0x04. A shadow register that loads too early changes the pin level within the same period in which the write happened. The bench catches this by sampling the pin at a known count right after the write. A broken prescaler or source selection stretches or shrinks every period by a whole factor, so a fixed-length window of cycles exposes it at once.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PS_W   = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] A_TOP   = 8'h08;
    localparam logic [ADDR_W-1:0] A_START = 8'h4C;
    localparam logic [ADDR_W-1:0] A_INIT  = 8'h5C;
    localparam logic [ADDR_W-1:0] A_MASK  = 8'h60;
    localparam int CH_BASE   = 12;
    localparam int CH_STRIDE = 8;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } src_sel_e;

    // bit 5 center mode, bits 4:3 source, bits 2:0 prescale exponent
    typedef struct packed {
        logic             center;
        src_sel_e         src;
        logic [PS_W-1:0]  ps;
    } tmr_ctrl_t;

    typedef struct packed {
        logic pwm_en;
        logic high_true;
        logic low_true;
    } ch_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    function automatic logic [ADDR_W-1:0] ch_ctrl_addr(int n);
        return ADDR_W'(CH_BASE + CH_STRIDE * n);
    endfunction

    function automatic logic [ADDR_W-1:0] ch_cmp_addr(int n);
        return ADDR_W'(CH_BASE + 4 + CH_STRIDE * n);
    endfunction

    function automatic logic [5:0] ch_ctrl_word(ch_ctrl_t c);
        return {c.pwm_en, 1'b0, c.high_true, c.low_true, 2'b00};
    endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            src_en,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = PRE_W'((1 << ps) - 1);
    assign tick  = src_en && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (src_en) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end

    AST_PS_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pre_q == '0)); // R3
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             center,
    input  logic             restart,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d, dec;
    logic             down_q, down_d;

    assign dec = cnt_q - CNT_W'(1);

    always_comb begin
        cnt_d  = cnt_q;
        down_d = down_q;
        wrap_o = 1'b0;
        if (tick) begin
            if (!center) begin
                down_d = 1'b0;
                if (cnt_q >= top) begin
                    cnt_d  = start;
                    wrap_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end else if (!down_q) begin
                if (cnt_q >= top) begin
                    if (top > start) begin
                        cnt_d = dec;
                        if (dec <= start) begin
                            down_d = 1'b0;
                            wrap_o = 1'b1;
                        end else begin
                            down_d = 1'b1;
                        end
                    end else begin
                        cnt_d  = start;
                        wrap_o = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end else begin
                cnt_d = dec;
                if (dec <= start) begin
                    down_d = 1'b0;
                    wrap_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (restart) begin
            cnt_q  <= start;
            down_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign down_o = down_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt_q)); // R2
    AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !center && !restart && cnt_q >= top) |=> (cnt_q == $past(start))); // R4
    AST_CTR_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (tick && center && down_q && !restart && cnt_q <= start + CNT_W'(1)) |=> !down_q); // R5
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  logic             running,
    input  ch_ctrl_t         ctrl,
    input  logic             init_bit,
    input  logic             mask_bit,
    output logic [CNT_W-1:0] cmp_shadow_o,
    output logic             pin_o
);
    logic [CNT_W-1:0] cmp_sh_q, cmp_act_q;
    logic             active, low_pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_sh_q  <= '0;
            cmp_act_q <= '0;
        end else begin
            if (cmp_wr) cmp_sh_q  <= cmp_wdata;
            if (load)   cmp_act_q <= cmp_sh_q;
        end
    end

    // rising sweep: active below compare; falling sweep: active at or below
    assign active  = down ? (cnt <= cmp_act_q) : (cnt < cmp_act_q);
    assign low_pol = !ctrl.high_true && ctrl.low_true;

    always_comb begin
        if (mask_bit)
            pin_o = low_pol;
        else if (!running || !ctrl.pwm_en)
            pin_o = init_bit;
        else
            pin_o = active ^ low_pol;
    end

    assign cmp_shadow_o = cmp_sh_q;

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cmp_act_q)); // R8
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fix_tick,
    input  logic              ext_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   pwm_out
);
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] start_q, top_sh_q, top_act_q;
    logic [N_CH-1:0]  init_q, mask_q;
    ch_ctrl_t         ch_ctrl_q [N_CH];
    logic [CNT_W-1:0] cmp_sh [N_CH];

    logic             src_en, running, tick, cnt_wr, wrap, load, down;
    logic [CNT_W-1:0] cnt;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign running      = (ctrl_q.src != SRC_OFF);
    assign cnt_wr       = bus_wr && (bus_addr == A_COUNT);
    assign load         = wrap || !running || cnt_wr;

    always_comb begin
        unique case (ctrl_q.src)
            SRC_OFF: src_en = 1'b0;
            SRC_SYS: src_en = 1'b1;
            SRC_FIX: src_en = fix_tick;
            SRC_EXT: src_en = ext_tick;
            default: src_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            start_q   <= '0;
            top_sh_q  <= '0;
            top_act_q <= '0;
            init_q    <= '0;
            mask_q    <= '0;
            for (int i = 0; i < N_CH; i++) ch_ctrl_q[i] <= '0;
        end else begin
            if (bus_wr) begin
                if (bus_addr == A_CTRL)  ctrl_q   <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                if (bus_addr == A_START) start_q  <= bus_wdata[CNT_W-1:0];
                if (bus_addr == A_TOP)   top_sh_q <= bus_wdata[CNT_W-1:0];
                if (bus_addr == A_INIT)  init_q   <= bus_wdata[N_CH-1:0];
                if (bus_addr == A_MASK)  mask_q   <= bus_wdata[N_CH-1:0];
                for (int i = 0; i < N_CH; i++) begin
                    if (bus_addr == ch_ctrl_addr(i)) begin
                        ch_ctrl_q[i].pwm_en    <= bus_wdata[5];
                        ch_ctrl_q[i].high_true <= bus_wdata[3];
                        ch_ctrl_q[i].low_true  <= bus_wdata[2];
                    end
                end
            end
            if (load) top_act_q <= top_sh_q;
        end
    end

    pwm_prescale #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (cnt_wr),
        .src_en  (src_en),
        .ps      (ctrl_q.ps),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .center  (ctrl_q.center),
        .restart (cnt_wr),
        .start   (start_q),
        .top     (top_act_q),
        .cnt_o   (cnt),
        .down_o  (down),
        .wrap_o  (wrap)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic cmp_hit;
        assign cmp_hit = bus_wr && (bus_addr == ch_cmp_addr(g));
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk          (clk),
            .rst          (rst),
            .cmp_wr       (cmp_hit),
            .cmp_wdata    (bus_wdata[CNT_W-1:0]),
            .load         (load),
            .cnt          (cnt),
            .down         (down),
            .running      (running),
            .ctrl         (ch_ctrl_q[g]),
            .init_bit     (init_q[g]),
            .mask_bit     (mask_q[g]),
            .cmp_shadow_o (cmp_sh[g]),
            .pin_o        (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)  bus_rdata = DATA_W'(ctrl_q);
        if (bus_addr == A_COUNT) bus_rdata = DATA_W'(cnt);
        if (bus_addr == A_TOP)   bus_rdata = DATA_W'(top_sh_q);
        if (bus_addr == A_START) bus_rdata = DATA_W'(start_q);
        if (bus_addr == A_INIT)  bus_rdata = DATA_W'(init_q);
        if (bus_addr == A_MASK)  bus_rdata = DATA_W'(mask_q);
        for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == ch_ctrl_addr(i)) bus_rdata = DATA_W'(ch_ctrl_word(ch_ctrl_q[i]));
            if (bus_addr == ch_cmp_addr(i))  bus_rdata = DATA_W'(cmp_sh[i]);
        end
    end

    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(top_act_q)); // R8
endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fix_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pwm_out;

    always #2 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst(rst), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag_q[$];
    int    exp_q[$];
    int    act_q[$];
    int    hc[8];

    // scoreboard: expected and observed values are queued, the monitor compares
    task automatic check(string tag, int act, int exp);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        act_q.push_back(act);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                string t;
                int e, a;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_chk++;
                if (a != e) begin
                    n_fail++;
                    $display("FAIL %s: actual %0d expected %0d", t, a, e);
                end
            end
        end
    end

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k = (k + 1) % 4;
            fix_tick = (k == 0);
        end
    end

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic count_all(input int ncyc);
        for (int i = 0; i < 8; i++) hc[i] = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            for (int i = 0; i < 8; i++) if (pwm_out[i]) hc[i]++;
        end
    endtask

    task automatic period(input int ch, output int n);
        logic s0, s1;
        int guard;
        guard = 0;
        s0 = pwm_out[ch];
        forever begin
            @(negedge clk); s1 = pwm_out[ch]; guard++;
            if ((!s0 && s1) || guard > 3000) break;
            s0 = s1;
        end
        n = 0; s0 = 1'b1;
        forever begin
            @(negedge clk); n++; s1 = pwm_out[ch];
            if ((!s0 && s1) || n > 3000) break;
            s0 = s1;
        end
    endtask

    task automatic poll_cnt(input int val, input int limit, output int found);
        int v;
        found = 0;
        for (int i = 0; i < limit; i++) begin
            rd(8'h04, v);
            if (v == val) begin found = 1; break; end
        end
    endtask

    task automatic ch_cfg(input int ch, input int ctl, input int cmp);
        wr(8'(12 + 8 * ch), ctl);
        wr(8'(16 + 8 * ch), cmp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, f;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 pins", int'(pwm_out), 0);
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h04, v); check("R1 count", v, 0);
        rd(8'h08, v); check("R1 top", v, 0);

        // edge-aligned, start 0, top 9
        wr(8'h4C, 0); wr(8'h08, 9);
        ch_cfg(0, 32'h28, 3);
        ch_cfg(1, 32'h24, 6);
        ch_cfg(2, 32'h28, 0);
        ch_cfg(3, 32'h28, 10);
        ch_cfg(6, 32'h2C, 10);
        wr(8'h04, 0); wr(8'h00, 32'h08);
        repeat (20) @(negedge clk);
        count_all(50);
        check("R4 edge high", hc[0], 15);
        check("R6 active-low", hc[1], 20);
        check("R7 cmp at start", hc[2], 0);
        check("R7 cmp above top", hc[3], 50);
        check("R6 high-true precedence", hc[6], 50);
        check("R10 pwm disabled uses init", hc[4], 0);
        period(0, v); check("R4 edge period", v, 10);

        // R12 readback
        rd(8'h14, v); check("R12 ch1 ctrl", v, 32'h24);
        rd(8'h18, v); check("R12 ch1 cmp", v, 6);
        rd(8'h00, v); check("R12 ctrl", v, 32'h08);
        rd(8'h08, v); check("R12 top", v, 9);

        // R8 buffering of compare and top while running
        wr(8'h08, 99); wr(8'h10, 50);
        poll_cnt(60, 400, f); check("R8 top loaded at reload", f, 1);
        poll_cnt(10, 400, f);
        wr(8'h10, 20);
        poll_cnt(30, 400, f);
        check("R8 compare held this period", int'(pwm_out[0]), 1);
        poll_cnt(99, 400, f);
        poll_cnt(30, 400, f);
        check("R8 compare used next period", int'(pwm_out[0]), 0);
        poll_cnt(40, 400, f);
        wr(8'h08, 29);
        poll_cnt(60, 100, f); check("R8 top held this period", f, 1);
        period(0, v); check("R8 new top period", v, 30);

        // R5 center-aligned
        wr(8'h00, 0); wr(8'h08, 5); wr(8'h10, 2);
        wr(8'h04, 0); wr(8'h00, 32'h28);
        repeat (20) @(negedge clk);
        count_all(50);
        check("R5 center high", hc[0], 20);
        check("R7 center cmp above top", hc[3], 50);
        check("R7 center cmp at start", hc[2], 0);
        check("R6 center active-low", hc[1], 0);
        period(0, v); check("R5 center period", v, 10);

        // R4 nonzero start value
        wr(8'h00, 0); wr(8'h4C, 4); wr(8'h08, 9); wr(8'h10, 6);
        wr(8'h04, 0); wr(8'h00, 32'h08);
        repeat (20) @(negedge clk);
        count_all(60);
        check("R4 start offset high", hc[0], 20);
        check("R7 cmp below start", hc[2], 0);
        check("R6 active-low with start", hc[1], 40);

        // R3 prescaler divide by 4
        wr(8'h00, 0); wr(8'h4C, 0); wr(8'h10, 3);
        wr(8'h04, 0); wr(8'h00, 32'h0A);
        repeat (50) @(negedge clk);
        count_all(80);
        check("R3 prescaled high", hc[0], 24);
        period(0, v); check("R3 prescaled period", v, 40);

        // R2 fixed tick source
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h00, 32'h10);
        repeat (50) @(negedge clk);
        count_all(80);
        check("R2 fixed source high", hc[0], 24);
        period(0, v); check("R2 fixed source period", v, 40);

        // R2 external tick source
        wr(8'h00, 0); wr(8'h08, 1000); wr(8'h04, 0); wr(8'h00, 32'h18);
        rd(8'h04, v); check("R2 ext idle", v, 0);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
            @(negedge clk);
        end
        rd(8'h04, v); check("R2 ext count", v, 5);

        // R2 stopped source holds the count
        wr(8'h00, 32'h08);
        repeat (7) @(negedge clk);
        wr(8'h00, 0);
        rd(8'h04, v);
        repeat (10) @(negedge clk);
        rd(8'h04, f); check("R2 stopped holds", f, v);

        // R11 counter write restarts at start value
        wr(8'h4C, 7); wr(8'h04, 0);
        rd(8'h04, v); check("R11 restart value", v, 7);

        // R10 init levels while stopped
        wr(8'h5C, 32'hA5);
        @(negedge clk);
        check("R10 stopped pins follow init", int'(pwm_out), 32'hA5);

        // R9 mask, R10 init on non-PWM channels while running
        wr(8'h4C, 0); wr(8'h08, 9); wr(8'h10, 3); wr(8'h1C, 0);
        wr(8'h60, 32'h0B);
        wr(8'h04, 0); wr(8'h00, 32'h08);
        repeat (20) @(negedge clk);
        count_all(50);
        check("R9 masked high-true", hc[0], 0);
        check("R9 masked active-low", hc[1], 50);
        check("R9 masked always-active", hc[3], 0);
        check("R10 running init bit1", hc[5], 50);
        check("R10 running init bit0", hc[4], 0);
        rd(8'h60, v); check("R12 mask readback", v, 32'h0B);

        repeat (5) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule